// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects fourteen interrupt lines and turns them into one request to the processor core and a dispatch index. The lines are two software bits (lines 1 and 0), ten external hardware inputs (lines 11 down to 2), a timer input (line 12) and a performance-counter input (line 13). Line 7 is an ordinary external line. Each line has its own pending bit, its own enable (mask) bit and its own 4-bit priority. A combinational arbiter picks the winning line among those that are both pending and enabled.

Software reaches the block through a plain register port with three operations. A write takes effect at the rising clock edge while `reg_wr_i` is high. A read returns the word at `reg_addr_i` in the same cycle. The port has no back-pressure and every access completes at once, so it has no valid/ready pair. Address 0 holds a status word laid out like a cause register: it carries the pending field, a vectored-dispatch enable and storage for the branch-delay, coprocessor, watch and exception-code fields that the core fills in. Address 1 holds the enable bits. Addresses 2 and 3 hold the per-line priorities.

When vectored dispatch is on, the index output names the winning line. When it is off, the index output carries one common index for every source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The hardware pending bits are set by these inputs: `ext_irq_i[j]` drives line j+2, `timer_irq_i` drives line 12 and `perf_irq_i` drives line 13. Each of these bits follows its level input with one register of delay. Line n appears at bit 8+n of the word at address 0.
- R2: A write to address 0 loads `reg_wdata_i[9:8]` into the pending bits of software lines 1:0. The write has no effect on the hardware pending bits 21:10.
- R3: Address 1 bits 13:0 are the enable bits, where 1 enables a line. Bits 31:14 of address 1 read as zero.
- R4: `irq_req_o` is high exactly when some line is both pending and enabled and `gie_i` is high. `gie_i` acts on `irq_req_o` combinationally.
- R5: Each line has a 4-bit priority. Lines 0–7 use address 2 and lines 8–13 use address 3, with line n in bits 4*(n mod 8)+3 : 4*(n mod 8). Among the eligible lines, the one with the largest priority value wins. Address 3 bits 31:24 read as zero.
- R6: When eligible lines share the highest priority value, the lowest line number wins.
- R7: When bit 24 (vectored dispatch) of address 0 is 1 and `irq_req_o` is high, `irq_vec_o` equals the winning line number.
- R8: When vectored dispatch is 0, or when `irq_req_o` is low, `irq_vec_o` equals `COMMON_VEC` (default 15).
- R9: Address 0 stores the following writable fields, each read back at the same position: bit 31 (branch delay), bits 29:28 (coprocessor), bit 26 (watch 2), bit 25 (watch 1), bit 24 (vectored dispatch) and bits 6:2 (exception code).
- R10: In address 0, bits 30, 27, 7, 1:0 and 23:22 (pending for the unused lines 15:14) read as zero. Addresses 4 to 7 read as zero.
- R11: After reset, every register is zero, `irq_req_o` is low and `irq_vec_o` equals `COMMON_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable from the core |
| ext_irq_i | input | 10 | External level interrupts, lines 11:2 |
| timer_irq_i | input | 1 | Timer level interrupt, line 12 |
| perf_irq_i | input | 1 | Performance-counter level interrupt, line 13 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 4 | Dispatch index |

## Verification
The assertions assume that the interrupt lines are already synchronous to `clk_i`. They also assume that the core holds `reg_addr_i` steady around the sampling point whenever it relies on the combinational read data. The bench drives every input on the falling clock edge and reads only after a short settle. Because of this, the pending-tracking and software-write properties always compare a registered value with the input it sampled one edge before. The priorities are programmed once, ahead of the vector table, so each row's expected winner depends only on that row's lines, enables and dispatch mode.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_LINES    = 14;
  localparam int N_SW       = 2;
  localparam int N_EXT      = 10;
  localparam int TIMER_LINE = 12;
  localparam int PERF_LINE  = 13;
  localparam int PRIO_W     = 4;
  localparam int IDX_W      = 4;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int IP_W       = 16;
  localparam int IP_LSB     = 8;
  localparam int SLOTS      = DATA_W / PRIO_W;

  localparam int ADDR_CAUSE   = 0;
  localparam int ADDR_ENABLE  = 1;
  localparam int ADDR_PRIO_LO = 2;

  localparam int BD_BIT  = 31;
  localparam int CE_LSB  = 28;
  localparam int W2_BIT  = 26;
  localparam int W1_BIT  = 25;
  localparam int IV_BIT  = 24;
  localparam int EXC_LSB = 2;
  localparam int EXC_W   = 5;

  typedef struct packed {
    logic             bd;
    logic [1:0]       ce;
    logic             w2;
    logic             w1;
    logic             iv;
    logic [EXC_W-1:0] exc;
  } cause_ctl_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_EXT-1:0]   ext_i,
  input  logic               timer_i,
  input  logic               perf_i,
  input  logic               sw_we_i,
  input  logic [N_SW-1:0]    sw_wdata_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] hw_lvl;

  // Map each hardware input onto its line number.
  always_comb begin
    hw_lvl             = '0;
    hw_lvl[TIMER_LINE] = timer_i;
    hw_lvl[PERF_LINE]  = perf_i;
    hw_lvl[N_SW +: N_EXT] = ext_i;
  end

  for (genvar gl = 0; gl < N_LINES; gl++) begin : g_line
    if (gl < N_SW) begin : g_sw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      pend_o[gl] <= 1'b0;
        else if (sw_we_i) pend_o[gl] <= sw_wdata_i[gl];
      end
    end else begin : g_hw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_o[gl] <= 1'b0;
        else         pend_o[gl] <= hw_lvl[gl];
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_LINES-1:0]             enable_o,
  output logic [N_LINES-1:0][PRIO_W-1:0] prio_o,
  output cause_ctl_t                     cause_o
);
  logic hit_cause, hit_enable;
  assign hit_cause  = wr_i && (addr_i == ADDR_W'(ADDR_CAUSE));
  assign hit_enable = wr_i && (addr_i == ADDR_W'(ADDR_ENABLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
    end else if (hit_cause) begin
      cause_o.bd  <= wdata_i[BD_BIT];
      cause_o.ce  <= wdata_i[CE_LSB +: 2];
      cause_o.w2  <= wdata_i[W2_BIT];
      cause_o.w1  <= wdata_i[W1_BIT];
      cause_o.iv  <= wdata_i[IV_BIT];
      cause_o.exc <= wdata_i[EXC_LSB +: EXC_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         enable_o <= '0;
    else if (hit_enable) enable_o <= wdata_i[N_LINES-1:0];
  end

  // One priority field per line; the word and slot follow from the line number.
  for (genvar gp = 0; gp < N_LINES; gp++) begin : g_prio
    localparam int WORD = ADDR_PRIO_LO + gp / SLOTS;
    localparam int SLOT = gp % SLOTS;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_o[gp] <= '0;
      else if (wr_i && addr_i == ADDR_W'(WORD))
        prio_o[gp] <= wdata_i[SLOT*PRIO_W +: PRIO_W];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [N_LINES-1:0]             pend_i,
  input  logic [N_LINES-1:0]             enable_i,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               win_o
);
  logic [PRIO_W-1:0] best;

  // Scan from the top line down; ">=" lets a lower line take over a tie.
  always_comb begin
    found_o = 1'b0;
    win_o   = '0;
    best    = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend_i[i] && enable_i[i] && (!found_o || prio_i[i] >= best)) begin
        found_o = 1'b1;
        best    = prio_i[i];
        win_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter logic [IDX_W-1:0] COMMON_VEC = 4'd15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gie_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              timer_irq_i,
  input  logic              perf_irq_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_vec_o
);
  logic [N_LINES-1:0]             pend;
  logic [N_LINES-1:0]             enable;
  logic [N_LINES-1:0][PRIO_W-1:0] prio;
  cause_ctl_t                     cause_q;
  logic                           found;
  logic [IDX_W-1:0]               win;
  logic                           sw_we;

  assign sw_we = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CAUSE));

  irq_src_bank u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_irq_i),
    .timer_i    (timer_irq_i),
    .perf_i     (perf_irq_i),
    .sw_we_i    (sw_we),
    .sw_wdata_i (reg_wdata_i[IP_LSB +: N_SW]),
    .pend_o     (pend)
  );

  irq_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .enable_o (enable),
    .prio_o   (prio),
    .cause_o  (cause_q)
  );

  irq_arbiter u_arb (
    .pend_i   (pend),
    .enable_i (enable),
    .prio_i   (prio),
    .found_o  (found),
    .win_o    (win)
  );

  assign irq_req_o = found && gie_i;
  assign irq_vec_o = (irq_req_o && cause_q.iv) ? win : COMMON_VEC;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CAUSE)) begin
      reg_rdata_o[BD_BIT]              = cause_q.bd;
      reg_rdata_o[CE_LSB +: 2]         = cause_q.ce;
      reg_rdata_o[W2_BIT]              = cause_q.w2;
      reg_rdata_o[W1_BIT]              = cause_q.w1;
      reg_rdata_o[IV_BIT]              = cause_q.iv;
      reg_rdata_o[IP_LSB +: IP_W]      = IP_W'(pend);
      reg_rdata_o[EXC_LSB +: EXC_W]    = cause_q.exc;
    end else if (reg_addr_i == ADDR_W'(ADDR_ENABLE)) begin
      reg_rdata_o[N_LINES-1:0] = enable;
    end else begin
      for (int i = 0; i < N_LINES; i++) begin
        if (int'(reg_addr_i) == ADDR_PRIO_LO + i / SLOTS)
          reg_rdata_o[(i % SLOTS) * PRIO_W +: PRIO_W] = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
#(
  parameter logic [IDX_W-1:0] COMMON_VEC = 4'd15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gie_i,
  input logic [N_EXT-1:0]  ext_irq_i,
  input logic              timer_irq_i,
  input logic              perf_irq_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [N_SW-1:0]   sw_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_req_o,
  input logic [IDX_W-1:0]  irq_vec_o,
  input logic              iv_i,
  input logic [N_SW-1:0]   sw_pend_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_hw_pend_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && reg_addr_i == ADDR_W'(ADDR_CAUSE)) |->
      reg_rdata_o[21:10] == $past({perf_irq_i, timer_irq_i, ext_irq_i}));

  assert_sw_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CAUSE)) |=> sw_pend_i == $past(sw_wdata_i));

  assert_req_needs_gie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> gie_i);

  assert_vec_is_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && iv_i) |-> int'(irq_vec_o) < N_LINES);

  assert_common_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o || !iv_i) |-> irq_vec_o == COMMON_VEC);

  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(ADDR_CAUSE)) |->
      (reg_rdata_o[30] == 1'b0 && reg_rdata_o[27] == 1'b0 && reg_rdata_o[7] == 1'b0 &&
       reg_rdata_o[1:0] == 2'b00 && reg_rdata_o[23:22] == 2'b00));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_addr_i) > 3) |-> reg_rdata_o == '0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.COMMON_VEC(COMMON_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gie_i       (gie_i),
  .ext_irq_i   (ext_irq_i),
  .timer_irq_i (timer_irq_i),
  .perf_irq_i  (perf_irq_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .sw_wdata_i  (reg_wdata_i[9:8]),
  .reg_rdata_o (reg_rdata_o),
  .irq_req_o   (irq_req_o),
  .irq_vec_o   (irq_vec_o),
  .iv_i        (cause_q.iv),
  .sw_pend_i   (pend[1:0])
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic [9:0]  ext = '0;
  logic        tmr = 1'b0;
  logic        perf = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [3:0]  irq_vec;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .ext_irq_i(ext),
    .timer_irq_i(tmr), .perf_irq_i(perf), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_req_o(irq_req), .irq_vec_o(irq_vec)
  );

  // Row: {ext[9:0], timer, perf, enable[13:0], gie, iv, exp_req, exp_vec[3:0]}
  // Priorities: line3=9, line5=12, line7=9, line12=5, line13=2, all others 0.
  localparam logic [32:0] TBL [NV] = '{
    {10'h020, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd7},   // R7 line 7 vectored
    {10'h020, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b0, 1'b1, 4'd15},  // R8 common index
    {10'h022, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd3},   // R6 tie 3 vs 7
    {10'h02A, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd5},   // R5 highest value
    {10'h02A, 1'b0, 1'b0, 14'h3FDF, 1'b1, 1'b1, 1'b1, 4'd3},   // R3 line 5 disabled
    {10'h000, 1'b1, 1'b1, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd12},  // R5 timer over perf
    {10'h000, 1'b0, 1'b1, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd13},  // R1 perf on line 13
    {10'h020, 1'b0, 1'b0, 14'h3FFF, 1'b0, 1'b1, 1'b0, 4'd15},  // R4 gie low
    {10'h3FF, 1'b1, 1'b1, 14'h0000, 1'b1, 1'b1, 1'b0, 4'd15},  // R3 all disabled
    {10'h005, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd2},   // R6 tie at zero
    {10'h008, 1'b1, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd5},   // R5 line 5 over timer
    {10'h200, 1'b0, 1'b0, 14'h3FFF, 1'b1, 1'b1, 1'b1, 4'd11}   // R1 line 11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    applied++;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      check("R11 reset register", d, 32'h0);
    end
    check("R11 reset req", {31'h0, irq_req}, 32'h0);
    check("R11 reset vec", {28'h0, irq_vec}, 32'd15);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 priority programming and readback
    wr(3'd2, 32'h90C0_9000);
    wr(3'd3, 32'h0025_0000);
    rd(3'd2, d); check("R5 prio word lo", d, 32'h90C0_9000);
    rd(3'd3, d); check("R5 prio word hi", d, 32'h0025_0000);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [32:0] row;
      row = TBL[v];
      wr(3'd1, {18'h0, row[20:7]});
      wr(3'd0, {7'h0, row[5], 24'h0});
      ext = row[32:23]; tmr = row[22]; perf = row[21]; gie = row[6];
      @(negedge clk);
      rd(3'd0, d);
      check("R1 pending field", {16'h0, d[23:8]}, {16'h0, 2'b00, row[21], row[22], row[32:23], 2'b00});
      check("R4 request", {31'h0, irq_req}, {31'h0, row[4]});
      check("R7/R8 vector", {28'h0, irq_vec}, {28'h0, row[3:0]});
    end

    // R2 software bits, hardware bits not writable
    ext = '0; tmr = 1'b0; perf = 1'b0; gie = 1'b1;
    wr(3'd1, 32'h0000_0003);
    wr(3'd0, 32'h0110_0300);
    rd(3'd0, d);
    check("R2 software pending set, bit 20 ignored", {16'h0, d[23:8]}, 32'h0000_0003);
    check("R6 software tie picks line 0", {28'h0, irq_vec}, 32'd0);
    wr(3'd0, 32'h0100_0200);
    rd(3'd0, d);
    check("R2 software pending line 1 only", {16'h0, d[23:8]}, 32'h0000_0002);
    check("R7 vector line 1", {28'h0, irq_vec}, 32'd1);

    // R4 gie acts combinationally
    gie = 1'b0; #1;
    check("R4 gie low drops req", {31'h0, irq_req}, 32'h0);
    check("R8 vector when no req", {28'h0, irq_vec}, 32'd15);
    gie = 1'b1; #1;
    check("R4 gie high restores req", {31'h0, irq_req}, 32'h1);

    // R9 / R10 field storage and reserved bits
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d);
    check("R9 R10 status word", d, 32'hB700_037C);
    rd(3'd5, d); check("R10 unmapped address", d, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R3 enable width", d, 32'h0000_3FFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R5 prio hi upper bits", d, 32'h00FF_FFFF);

    // R11 reset again clears everything
    rst_n = 1'b0; #1;
    rd(3'd0, d); check("R11 reset clears status", d, 32'h0);
    check("R11 reset clears vec", {28'h0, irq_vec}, 32'd15);
    @(negedge clk);
    finish_run();
  end
endmodule